// File: doc/BRIEF.md
# SD Command Response Checker

After a host command has been sent, this block receives the card's 48-bit short response serially from the command line and checks it. A start strobe arms the block and latches the command index that the response should carry, together with a limit on how long the block waits. While armed, the block watches the command line on the clock cycles where the sample enable is high. It takes the first low sample as the start bit of the response. If the line stays high for longer than the limit allows, the block gives up and reports a timeout.

Once the start bit has been seen, the block shifts in the remaining 47 bits. While it does so, it runs a CRC7 over the leading 40 bits of the frame. When the last bit arrives, it compares the transmission bit, the echoed command index, the CRC field and the end bit against their expected values. It reports each mismatch on a separate flag and presents the 32-bit argument field. A one-cycle done pulse marks the moment the flags and the argument become valid. They then stay unchanged until the next start strobe.

Top module: `sd_resp_checker`

## Requirements
- R1: After reset, done_o, all five error flags and arg_o are 0.
- R2: The line is examined only on cycles with smp_en_i high. The first low sample after a start strobe is the start bit, which is frame bit 47. The next 47 enabled samples are frame bits 46 down to 0, sent most significant first. Samples taken while smp_en_i is low have no effect.
- R3: With a limit L on max_lat_i, a start bit on any of the first L+1 enabled samples after the strobe is accepted. If those L+1 samples are all high, a timeout is reported at the (L+1)-th sample. A limit of 0 therefore times out on the first high sample.
- R4: When a timeout is reported, err_timeout_o is 1, the other four flags are 0 and arg_o is 0.
- R5: The CRC is computed with polynomial x^7+x^3+1 (feedback mask 0x09), a zero initial value and the MSB-first bit order, over frame bits 47 to 8. err_crc_o is set when the result differs from frame bits 7 to 1.
- R6: err_dir_o is set when frame bit 46, the transmission bit, is 1 rather than 0.
- R7: err_idx_o is set when frame bits 45 to 40 differ from exp_idx_i as latched at the start strobe.
- R8: err_end_o is set when frame bit 0 is 0.
- R9: done_o is high for exactly one cycle, the clock cycle after the sample that carried the end bit or caused the timeout. Frame bits 39 to 8 appear on arg_o from that cycle onward. The flags and arg_o hold until the next start strobe.
- R10: A start strobe clears all flags and restarts the wait, abandoning any response in progress. The strobe cycle's own sample is ignored.
- R11: Without a start strobe, no activity on the command line produces a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arms the checker for a new response |
| exp_idx_i | input | 6 | Expected command index, latched on start_i |
| max_lat_i | input | LAT_W | Latency limit in enabled samples, latched on start_i |
| smp_en_i | input | 1 | Command-line sample enable |
| cmd_i | input | 1 | Command-line bit |
| done_o | output | 1 | One-cycle end-of-check pulse |
| err_timeout_o | output | 1 | No start bit within the latency limit |
| err_crc_o | output | 1 | CRC7 mismatch |
| err_end_o | output | 1 | End bit not 1 |
| err_dir_o | output | 1 | Transmission bit not card-to-host |
| err_idx_o | output | 1 | Response index mismatch |
| arg_o | output | 32 | Argument field of the last response |

## Verification
The hardest cases to reach from the ports are the two sides of the latency boundary and an abandoned response. The latency boundary needs a start bit on exactly the last accepted sample, and a timeout one sample later. An abandoned response needs a start strobe to land partway through a frame.

The bench prefixes each frame with a counted run of idle-high samples, so a table row can place the start bit just inside or just outside the limit, including a limit of 0. A directed test cuts a frame off after a few bits with a new strobe, then checks that exactly one done pulse follows, for the second frame. Every disabled cycle drives the inverted line value, so any leak of the sample enable corrupts the frame.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;
  localparam int unsigned FRAME_LEN = 48;
  localparam int unsigned IDX_W     = 6;
  localparam int unsigned ARG_W     = 32;
  localparam int unsigned CRC_W     = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);
  // bits 46..1 are captured; bit k sits at shift position k-1
  localparam int unsigned SH_W      = FRAME_LEN - 2;
  localparam int unsigned DIR_BIT   = FRAME_LEN - 2;
  localparam int unsigned IDX_LO    = DIR_BIT - IDX_W;
  localparam int unsigned ARG_LO    = IDX_LO - ARG_W;
  localparam int unsigned CRC_LO    = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } sdrc_state_e;

  typedef struct packed {
    logic timeout;
    logic crc;
    logic endb;
    logic dir;
    logic idx;
  } sdrc_flags_t;
endpackage

// File: rtl/sdrc_crc7.sv
module sdrc_crc7 #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] POLY = 7'h09
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, crc_d;
  logic         fb;

  always_comb begin
    fb    = crc_q[W-1] ^ bit_i;
    crc_d = crc_q;
    if (clr_i) begin
      crc_d = '0;
    end else if (en_i) begin
      crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/sdrc_lat_timer.sv
module sdrc_lat_timer #(
  parameter int unsigned LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [LAT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             hit;

  always_comb begin
    hit   = tick_i && (cnt_q >= limit_i);
    cnt_d = cnt_q;
    if (clr_i)             cnt_d = '0;
    else if (tick_i && !hit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = hit;
endmodule

// File: rtl/sdrc_field_shift.sv
module sdrc_field_shift #(
  parameter int unsigned W = 46
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (en_i) sh_d = {sh_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q;
endmodule

// File: rtl/sd_resp_checker.sv
module sd_resp_checker
  import sdrc_pkg::*;
#(
  parameter int unsigned LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] exp_idx_i,
  input  logic [LAT_W-1:0] max_lat_i,
  input  logic             smp_en_i,
  input  logic             cmd_i,
  output logic             done_o,
  output logic             err_timeout_o,
  output logic             err_crc_o,
  output logic             err_end_o,
  output logic             err_dir_o,
  output logic             err_idx_o,
  output logic [ARG_W-1:0] arg_o
);
  localparam logic [POS_W-1:0] POS_FIRST = POS_W'(FRAME_LEN - 2);
  localparam logic [POS_W-1:0] POS_CRC   = POS_W'(ARG_LO);

  sdrc_state_e      state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [IDX_W-1:0] exp_q, exp_d;
  logic [LAT_W-1:0] lim_q, lim_d;
  sdrc_flags_t      flg_q, flg_d;
  logic [ARG_W-1:0] arg_q, arg_d;
  logic             done_q, done_d;

  logic             take;
  logic             tmr_tick, tmr_exp;
  logic             crc_en;
  logic [CRC_W-1:0] crc_val;
  logic             sh_en;
  logic [SH_W-1:0]  sh_val;
  logic             fire_to, fire_fr;

  assign take = smp_en_i && !start_i;

  sdrc_lat_timer #(.LAT_W(LAT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (start_i),
    .tick_i   (tmr_tick),
    .limit_i  (lim_q),
    .expire_o (tmr_exp)
  );

  sdrc_crc7 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (start_i),
    .en_i  (crc_en),
    .bit_i (cmd_i),
    .crc_o (crc_val)
  );

  sdrc_field_shift #(.W(SH_W)) u_sh (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (sh_en),
    .bit_i (cmd_i),
    .q_o   (sh_val)
  );

  // sequencing
  always_comb begin
    state_d  = state_q;
    pos_d    = pos_q;
    tmr_tick = 1'b0;
    crc_en   = 1'b0;
    sh_en    = 1'b0;
    fire_to  = 1'b0;
    fire_fr  = 1'b0;
    if (start_i) begin
      state_d = ST_WAIT;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (take) begin
            if (!cmd_i) begin
              state_d = ST_SHIFT;
              pos_d   = POS_FIRST;
            end else begin
              tmr_tick = 1'b1;
              if (tmr_exp) begin
                fire_to = 1'b1;
                state_d = ST_IDLE;
              end
            end
          end
        end
        ST_SHIFT: begin
          if (take) begin
            crc_en = (pos_q >= POS_CRC);
            if (pos_q == '0) begin
              fire_fr = 1'b1;
              state_d = ST_IDLE;
            end else begin
              sh_en = 1'b1;
              pos_d = pos_q - 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // result evaluation
  always_comb begin
    exp_d  = start_i ? exp_idx_i : exp_q;
    lim_d  = start_i ? max_lat_i : lim_q;
    flg_d  = flg_q;
    arg_d  = arg_q;
    done_d = fire_to || fire_fr;
    if (start_i) begin
      flg_d = '0;
    end else if (fire_to) begin
      flg_d         = '0;
      flg_d.timeout = 1'b1;
      arg_d         = '0;
    end else if (fire_fr) begin
      flg_d.timeout = 1'b0;
      flg_d.dir     = sh_val[DIR_BIT-1];
      flg_d.idx     = (sh_val[IDX_LO-1 +: IDX_W] != exp_q);
      flg_d.crc     = (sh_val[CRC_LO-1 +: CRC_W] != crc_val);
      flg_d.endb    = !cmd_i;
      arg_d         = sh_val[ARG_LO-1 +: ARG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      exp_q   <= '0;
      lim_q   <= '0;
      flg_q   <= '0;
      arg_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      exp_q   <= exp_d;
      lim_q   <= lim_d;
      flg_q   <= flg_d;
      arg_q   <= arg_d;
      done_q  <= done_d;
    end
  end

  assign done_o        = done_q;
  assign err_timeout_o = flg_q.timeout;
  assign err_crc_o     = flg_q.crc;
  assign err_end_o     = flg_q.endb;
  assign err_dir_o     = flg_q.dir;
  assign err_idx_o     = flg_q.idx;
  assign arg_o         = arg_q;
endmodule

// File: rtl/sdrc_checker.sv
module sdrc_checker #(
  parameter int unsigned ARG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             smp_en_i,
  input logic             done_o,
  input logic             err_timeout_o,
  input logic             err_crc_o,
  input logic             err_end_o,
  input logic             err_dir_o,
  input logic             err_idx_o,
  input logic [ARG_W-1:0] arg_o
);
  logic any_other;
  assign any_other = err_crc_o || err_end_o || err_dir_o || err_idx_o;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_TIMEOUT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_timeout_o) |-> (!any_other && arg_o == '0)); // R4

  AST_FLAG_RISE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_timeout_o) || $rose(err_crc_o) || $rose(err_end_o) ||
     $rose(err_dir_o) || $rose(err_idx_o)) |-> done_o); // R9

  AST_ARG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(arg_o)); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && !err_timeout_o && !any_other)); // R10

  AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(smp_en_i)); // R2
endmodule

bind sd_resp_checker sdrc_checker #(.ARG_W(sdrc_pkg::ARG_W)) u_sdrc_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .smp_en_i      (smp_en_i),
  .done_o        (done_o),
  .err_timeout_o (err_timeout_o),
  .err_crc_o     (err_crc_o),
  .err_end_o     (err_end_o),
  .err_dir_o     (err_dir_o),
  .err_idx_o     (err_idx_o),
  .arg_o         (arg_o)
);

// File: tb/sd_resp_checker_bench.sv
module sd_resp_checker_bench;
  localparam int LAT_W = 16;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [5:0]       exp_idx_i;
  logic [LAT_W-1:0] max_lat_i;
  logic             smp_en_i;
  logic             cmd_i;
  logic             done_o;
  logic             err_timeout_o, err_crc_o, err_end_o, err_dir_o, err_idx_o;
  logic [31:0]      arg_o;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int cycles = 0;

  sd_resp_checker #(.LAT_W(LAT_W)) u_sd_resp_checker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .exp_idx_i(exp_idx_i),
    .max_lat_i(max_lat_i), .smp_en_i(smp_en_i), .cmd_i(cmd_i),
    .done_o(done_o), .err_timeout_o(err_timeout_o), .err_crc_o(err_crc_o),
    .err_end_o(err_end_o), .err_dir_o(err_dir_o), .err_idx_o(err_idx_o),
    .arg_o(arg_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) if (done_o) done_cnt++;

  // mode: 0 clean, 1 CRC field flipped, 2 direction bit set, 3 end bit cleared
  // layout: {mode[2:0], lead[7:0], lat[7:0], exp_idx[5:0], idx[5:0], arg[31:0]}
  localparam int NV = 9;
  localparam logic [62:0] VEC [NV] = '{
    {3'd0, 8'd2, 8'd5, 6'd17, 6'd17, 32'hDEADBEEF},
    {3'd0, 8'd1, 8'd5, 6'd5,  6'd3,  32'h0000FFFF},
    {3'd1, 8'd0, 8'd5, 6'd40, 6'd40, 32'hA5A5A5A5},
    {3'd2, 8'd3, 8'd5, 6'd8,  6'd8,  32'h01234567},
    {3'd3, 8'd1, 8'd5, 6'd2,  6'd2,  32'hFFFFFFFF},
    {3'd0, 8'd4, 8'd4, 6'd9,  6'd9,  32'h80000001},
    {3'd0, 8'd5, 8'd4, 6'd9,  6'd9,  32'h13572468},
    {3'd0, 8'd0, 8'd0, 6'd63, 6'd63, 32'h12345678},
    {3'd0, 8'd1, 8'd0, 6'd1,  6'd1,  32'h0BADF00D}
  };

  function automatic logic [6:0] crc7(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = c[6] ^ d[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] mk_frame(input logic dir, input logic [5:0] idx,
                                          input logic [31:0] arg, input logic flip,
                                          input logic endb);
    logic [39:0] head = {1'b0, dir, idx, arg};
    logic [6:0]  c    = crc7(head) ^ (flip ? 7'h01 : 7'h00);
    return {head, c, endb};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [5:0] ex, input logic [LAT_W-1:0] lat);
    @(negedge clk);
    start_i = 1'b1; exp_idx_i = ex; max_lat_i = lat; smp_en_i = 1'b1; cmd_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; smp_en_i = 1'b0; cmd_i = 1'b1;
  endtask

  // drives lead idle samples then the frame; disabled cycles carry the inverted bit
  task automatic drive(input logic [47:0] fr, input int lead, input int nbits,
                       output bit seen);
    seen = 1'b0;
    for (int n = 0; n < lead + nbits && !seen; n++) begin
      smp_en_i = 1'b1;
      cmd_i    = (n < lead) ? 1'b1 : fr[47 - (n - lead)];
      @(negedge clk);
      if (done_o) seen = 1'b1;
      smp_en_i = 1'b0;
      cmd_i    = ~cmd_i;
      @(negedge clk);
    end
    cmd_i = 1'b1;
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk) cycles++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected<100000", cycles);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    bit seen;
    int d0;
    rst_n = 1'b0; start_i = 1'b0; exp_idx_i = '0; max_lat_i = '0;
    smp_en_i = 1'b0; cmd_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 done", done_o, 0);
    check("R1 flags", {err_timeout_o, err_crc_o, err_end_o, err_dir_o, err_idx_o}, 0);
    check("R1 arg", arg_o, 0);

    // R11 line activity without a strobe
    d0 = done_cnt;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); smp_en_i = 1'b1; cmd_i = k[0];
    end
    smp_en_i = 1'b0; cmd_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 no done without strobe", done_cnt - d0, 0);

    // table: R2..R9
    for (int v = 0; v < NV; v++) begin
      logic [2:0]  mode = VEC[v][62:60];
      int          lead = int'(VEC[v][59:52]);
      logic [7:0]  lat  = VEC[v][51:44];
      logic [5:0]  ex   = VEC[v][43:38];
      logic [5:0]  idx  = VEC[v][37:32];
      logic [31:0] arg  = VEC[v][31:0];
      logic        to   = (lead > int'(lat));
      logic [47:0] fr   = mk_frame(mode == 3'd2, idx, arg, mode == 3'd1, mode != 3'd3);
      d0 = done_cnt;
      strobe(ex, LAT_W'(lat));
      drive(fr, lead, 48, seen);
      repeat (2) @(negedge clk);
      check($sformatf("R9 vec%0d one done", v), done_cnt - d0, 1);
      check($sformatf("R3 vec%0d timeout", v), err_timeout_o, to);
      check($sformatf("R5 vec%0d crc", v), err_crc_o, !to && mode == 3'd1);
      check($sformatf("R6 vec%0d dir", v), err_dir_o, !to && mode == 3'd2);
      check($sformatf("R8 vec%0d end", v), err_end_o, !to && mode == 3'd3);
      check($sformatf("R7 vec%0d idx", v), err_idx_o, !to && ex != idx);
      check($sformatf("R4 R9 vec%0d arg", v), arg_o, to ? 32'h0 : arg);
    end

    // R9 flags held, R10 strobe clears them
    begin
      logic [47:0] fr = mk_frame(1'b0, 6'd12, 32'h55AA55AA, 1'b0, 1'b1);
      strobe(6'd13, 16'd3);
      drive(fr, 0, 48, seen);
      repeat (6) @(negedge clk);
      check("R9 idx flag held", err_idx_o, 1);
      check("R9 arg held", arg_o, 32'h55AA55AA);
      strobe(6'd12, 16'd3);
      check("R10 strobe clears flag", err_idx_o, 0);
      // R10 abandon mid-frame, restart with a clean response
      d0 = done_cnt;
      drive(fr, 1, 10, seen);
      strobe(6'd12, 16'd3);
      fr = mk_frame(1'b0, 6'd12, 32'hCAFE0042, 1'b0, 1'b1);
      drive(fr, 2, 48, seen);
      repeat (2) @(negedge clk);
      check("R10 single done after restart", done_cnt - d0, 1);
      check("R10 clean flags after restart",
            {err_timeout_o, err_crc_o, err_end_o, err_dir_o, err_idx_o}, 0);
      check("R10 arg after restart", arg_o, 32'hCAFE0042);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule